// File: doc/BRIEF.md
# Sub-word register write coalescer

This block sits between a CPU-side register port and an SD host controller whose register file accepts only aligned 32-bit accesses. Byte and halfword reads become one aligned word read, with the addressed lane shifted down. Byte writes, and halfword writes to ordinary registers, become a read-modify-write of the aligned word.

The controller can drop one of two writes that land within two card-clock periods of each other. The adapter therefore does not issue the block-size, block-count and transfer-mode halfwords when they are written. It keeps them in two shadow words and releases them only when the command halfword arrives. At that point at most two combined word writes go out, in a fixed order: the block word first, then the transfer/command word.

After every downstream write, the adapter holds off the upstream port while the card clock is slow. The length of that hold comes from the card-clock frequency input and the system-clock frequency parameter.

Top module: `subword_coalescer`

## Requirements
- R1: After reset `up_ready` is 1, `up_rvalid` is 0, and both shadow words are zero: a first command write produces one downstream write whose transfer half is 0.
- R2: A halfword read (`up_size`=1) performs one read of the aligned word (`dn_addr[1:0]`=0) and returns `(word >> 8*addr[1:0]) & 0xFFFF`.
- R3: A byte read (`up_size`=0) returns `(word >> 8*addr[1:0]) & 0xFF`.
- R4: A byte write reads the aligned word, replaces only the addressed byte lane and writes the word back. This includes bytes inside the block and command words.
- R5: A halfword write to any offset other than 0x04, 0x06, 0x0C and 0x0E is a read-modify-write of the addressed halfword lane.
- R6: Halfword writes to 0x04 (block size, low half) and 0x06 (block count, high half) merge into the block shadow and issue no downstream access.
- R7: A halfword write to 0x0C (transfer mode, low half) merges into the command shadow and issues no downstream access.
- R8: A halfword write to 0x0E (command, high half) with a nonzero block shadow first writes the block shadow to word 0x04 and clears it. It then writes the command shadow, merged with the command value, to word 0x0C.
- R9: A command write with a zero block shadow issues exactly one write, to word 0x0C. The command shadow keeps its transfer-mode half across commands.
- R10: Word accesses (`up_size`=2) pass straight through as one read or one write.
- R11: After each downstream write, when 0 < `card_hz` <= 400000, the port stays busy for an extra N·`SYS_MHZ` cycles, where N = ceil(4,000,000 / `card_hz`).
- R12: When `card_hz` = 0 the extra hold is 10·`SYS_MHZ` cycles.
- R13: When `card_hz` > 400000 no hold is added.
- R14: Only one access is in progress at a time. With a fast card clock, `up_ready` stays low for 2 cycles on a read, 3 on a read-modify-write, 1 on a word write and 0 on a shadowed write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| card_hz | input | 32 | Current card-clock frequency in Hz (0 = unknown) |
| up_req | input | 1 | Upstream access request |
| up_we | input | 1 | 1 = write, 0 = read |
| up_size | input | 2 | 0 byte, 1 halfword, 2 word |
| up_addr | input | ADDR_W | Byte address of the access |
| up_wdata | input | 32 | Write value, right-aligned |
| up_ready | output | 1 | Adapter idle; a request is taken on this edge |
| up_rvalid | output | 1 | One-cycle read-data strobe |
| up_rdata | output | 32 | Read value, right-aligned |
| dn_req | output | 1 | Downstream access strobe (one cycle) |
| dn_we | output | 1 | Downstream write |
| dn_addr | output | ADDR_W | Word-aligned downstream address |
| dn_wdata | output | 32 | Downstream write word |
| dn_rdata | input | 32 | Downstream read word, valid the cycle after a read strobe |

## Verification
The hardest state to reach is a command write that meets a nonzero block shadow while the card clock is slow. Here two writes, each followed by its own hold, must leave in block-then-command order. The stimulus programs block size and count, then a transfer mode, with no downstream traffic, and then issues the command. The bench's downstream model records the last two write addresses, and the hold is measured as the number of cycles `up_ready` stays low. A later command write checks that the block shadow was emptied and that the transfer half survived.

// File: rtl/coal_pkg.sv
package coal_pkg;
  typedef enum logic [1:0] {SZ_BYTE = 2'd0, SZ_HALF = 2'd1, SZ_WORD = 2'd2} acc_size_e;
  typedef enum logic [2:0] {ST_IDLE, ST_RD, ST_CAP, ST_WR, ST_STALL} coal_state_e;

  localparam logic [7:0] OFF_BLKSZ  = 8'h04;
  localparam logic [7:0] OFF_BLKCNT = 8'h06;
  localparam logic [7:0] OFF_XFER   = 8'h0C;
  localparam logic [7:0] OFF_CMD    = 8'h0E;

  localparam logic [31:0] SLOW_LIMIT_HZ = 32'd400_000;
  localparam logic [32:0] HOLD_BUDGET   = 33'd4_000_000;
  localparam int          UNKNOWN_US    = 10;

  function automatic logic [31:0] lane_mask(input logic [1:0] sz);
    case (sz)
      SZ_BYTE: lane_mask = 32'h0000_00FF;
      SZ_HALF: lane_mask = 32'h0000_FFFF;
      default: lane_mask = 32'hFFFF_FFFF;
    endcase
  endfunction

  function automatic logic [4:0] lane_shift(input logic [1:0] lo, input logic [1:0] sz);
    lane_shift = sz[1] ? 5'd0 : {lo, 3'b000};
  endfunction

  function automatic logic [31:0] lane_extract(input logic [31:0] word, input logic [1:0] lo,
                                               input logic [1:0] sz);
    lane_extract = (word >> lane_shift(lo, sz)) & lane_mask(sz);
  endfunction
endpackage

// File: rtl/coal_rst_sync.sv
module coal_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q  <= 1'b0;
      rst_n_s <= 1'b0;
    end else begin
      meta_q  <= 1'b1;
      rst_n_s <= meta_q;
    end
  end
endmodule

// File: rtl/coal_lane_merge.sv
module coal_lane_merge
  import coal_pkg::*;
(
  input  logic [1:0]  addr_lo,
  input  logic [1:0]  size,
  input  logic [31:0] base,
  input  logic [31:0] val,
  output logic [31:0] merged
);
  logic [4:0]  sh;
  logic [31:0] m;

  always_comb begin
    sh     = lane_shift(addr_lo, size);
    m      = lane_mask(size) << sh;
    merged = (base & ~m) | ((val & lane_mask(size)) << sh);
  end
endmodule

// File: rtl/coal_shadow_bank.sv
module coal_shadow_bank (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        blk_we,
  input  logic        blk_clr,
  input  logic [31:0] blk_d,
  input  logic        cmd_we,
  input  logic [31:0] cmd_d,
  output logic [31:0] blk_q,
  output logic [31:0] cmd_q
);
  logic        blk_en;
  logic [31:0] blk_nx;

  always_comb begin
    blk_en = blk_we | blk_clr;
    blk_nx = blk_clr ? 32'd0 : blk_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blk_q <= 32'd0;
      cmd_q <= 32'd0;
    end else begin
      if (blk_en) blk_q <= blk_nx;
      if (cmd_we) cmd_q <= cmd_d;
    end
  end

  assert_blk_emptied_R8: assert property (@(posedge clk) disable iff (!rst_n)
    blk_clr |=> (blk_q == 32'd0));
  assert_single_blk_op_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(blk_we && blk_clr));
endmodule

// File: rtl/coal_hold_timer.sv
module coal_hold_timer
  import coal_pkg::*;
#(
  parameter int SYS_MHZ = 200
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [31:0] card_hz,
  output logic        busy,
  output logic        done
);
  localparam int CW = (SYS_MHZ > 1) ? $clog2(SYS_MHZ) : 1;
  localparam logic [CW-1:0] CYC_LAST = CW'(SYS_MHZ - 1);
  localparam logic [3:0]    US_LAST  = 4'(UNKNOWN_US - 1);

  logic [CW-1:0] cyc_q, cyc_d;
  logic [3:0]    nus_q, nus_d;
  logic [32:0]   acc_q, acc_d, acc_sum;
  logic [31:0]   f_q;
  logic          fz_q, act_d, us_end, fin;

  always_comb begin
    us_end  = busy && (cyc_q == CYC_LAST);
    acc_sum = acc_q + {1'b0, f_q};
    fin     = fz_q ? (nus_q == US_LAST) : (acc_sum >= HOLD_BUDGET);
    done    = us_end && fin;
    act_d   = busy;
    cyc_d   = cyc_q;
    nus_d   = nus_q;
    acc_d   = acc_q;
    if (start) begin
      act_d = 1'b1;
      cyc_d = '0;
      nus_d = '0;
      acc_d = '0;
    end else if (busy) begin
      cyc_d = us_end ? '0 : cyc_q + 1'b1;
      if (us_end) begin
        nus_d = nus_q + 1'b1;
        acc_d = acc_sum;
        act_d = !fin;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      cyc_q <= '0;
      nus_q <= '0;
      acc_q <= '0;
      f_q   <= '0;
      fz_q  <= 1'b0;
    end else begin
      busy  <= act_d;
      cyc_q <= cyc_d;
      nus_q <= nus_d;
      acc_q <= acc_d;
      if (start) begin
        f_q  <= card_hz;
        fz_q <= (card_hz == 32'd0);
      end
    end
  end

  assert_hold_starts_R11: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);
  assert_hold_idle_start_R11: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);
  assert_hold_ends_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
endmodule

// File: rtl/subword_coalescer.sv
module subword_coalescer
  import coal_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int SYS_MHZ = 200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [31:0]       card_hz,
  input  logic              up_req,
  input  logic              up_we,
  input  logic [1:0]        up_size,
  input  logic [ADDR_W-1:0] up_addr,
  input  logic [31:0]       up_wdata,
  output logic              up_ready,
  output logic              up_rvalid,
  output logic [31:0]       up_rdata,
  output logic              dn_req,
  output logic              dn_we,
  output logic [ADDR_W-1:0] dn_addr,
  output logic [31:0]       dn_wdata,
  input  logic [31:0]       dn_rdata
);
  localparam logic [ADDR_W-1:0] ALIGN_M  = ~ADDR_W'(3);
  localparam logic [ADDR_W-1:0] BLK_WORD = ADDR_W'(OFF_BLKSZ) & ALIGN_M;
  localparam logic [ADDR_W-1:0] CMD_WORD = ADDR_W'(OFF_CMD) & ALIGN_M;

  logic rst_n_s;
  coal_state_e state_q, state_d;

  logic              r_we_q;
  logic [1:0]        r_size_q;
  logic [ADDR_W-1:0] r_addr_q;
  logic [31:0]       r_wdata_q;
  logic              rq_en;
  logic [ADDR_W-1:0] w_addr_q, w_addr_d;
  logic [31:0]       w_word_q, w_word_d;
  logic              w_en;
  logic              pend_q, pend_d;
  logic [31:0]       hold_q;
  logic              hold_en;
  logic              rvalid_d, rdata_en;

  logic        blk_we, blk_clr, cmd_we;
  logic [31:0] blk_q, cmd_q, sh_base, sh_merged, rmw_merged;
  logic        tmr_start, tmr_busy, tmr_done;

  logic [ADDR_W-1:0] up_aligned, r_aligned;
  logic hit_blk, hit_xfer, hit_cmd, is_half, slow, wr_fin;

  coal_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_s(rst_n_s));

  coal_shadow_bank u_shadow (
    .clk(clk), .rst_n(rst_n_s),
    .blk_we(blk_we), .blk_clr(blk_clr), .blk_d(sh_merged),
    .cmd_we(cmd_we), .cmd_d(sh_merged),
    .blk_q(blk_q), .cmd_q(cmd_q)
  );

  coal_lane_merge u_sh_merge (
    .addr_lo(up_addr[1:0]), .size(up_size), .base(sh_base), .val(up_wdata), .merged(sh_merged)
  );

  coal_lane_merge u_rmw_merge (
    .addr_lo(r_addr_q[1:0]), .size(r_size_q), .base(dn_rdata), .val(r_wdata_q),
    .merged(rmw_merged)
  );

  coal_hold_timer #(.SYS_MHZ(SYS_MHZ)) u_hold (
    .clk(clk), .rst_n(rst_n_s), .start(tmr_start), .card_hz(card_hz),
    .busy(tmr_busy), .done(tmr_done)
  );

  always_comb begin
    up_aligned = up_addr & ALIGN_M;
    r_aligned  = r_addr_q & ALIGN_M;
    is_half    = (up_size == SZ_HALF);
    hit_blk    = is_half && (up_addr == ADDR_W'(OFF_BLKSZ) || up_addr == ADDR_W'(OFF_BLKCNT));
    hit_xfer   = is_half && (up_addr == ADDR_W'(OFF_XFER));
    hit_cmd    = is_half && (up_addr == ADDR_W'(OFF_CMD));
    sh_base    = (hit_cmd || hit_xfer) ? cmd_q : blk_q;
    slow       = (card_hz <= SLOW_LIMIT_HZ);
    wr_fin     = ((state_q == ST_WR) && !slow) || ((state_q == ST_STALL) && tmr_done);

    up_ready = (state_q == ST_IDLE);
    dn_req   = (state_q == ST_RD) || (state_q == ST_WR);
    dn_we    = (state_q == ST_WR);
    dn_addr  = (state_q == ST_WR) ? w_addr_q : r_aligned;
    dn_wdata = w_word_q;
  end

  always_comb begin
    state_d   = state_q;
    rq_en     = 1'b0;
    w_en      = 1'b0;
    w_addr_d  = w_addr_q;
    w_word_d  = w_word_q;
    pend_d    = pend_q;
    hold_en   = 1'b0;
    rvalid_d  = 1'b0;
    rdata_en  = 1'b0;
    blk_we    = 1'b0;
    blk_clr   = 1'b0;
    cmd_we    = 1'b0;
    tmr_start = 1'b0;
    case (state_q)
      ST_IDLE: if (up_req) begin
        rq_en = 1'b1;
        if (!up_we) begin
          state_d = ST_RD;
        end else if (up_size[1]) begin
          w_en     = 1'b1;
          w_addr_d = up_aligned;
          w_word_d = up_wdata;
          state_d  = ST_WR;
        end else if (hit_blk) begin
          blk_we = 1'b1;
        end else if (hit_xfer) begin
          cmd_we = 1'b1;
        end else if (hit_cmd) begin
          w_en    = 1'b1;
          state_d = ST_WR;
          if (blk_q != 32'd0) begin
            w_addr_d = BLK_WORD;
            w_word_d = blk_q;
            blk_clr  = 1'b1;
            pend_d   = 1'b1;
            hold_en  = 1'b1;
          end else begin
            w_addr_d = up_aligned;
            w_word_d = sh_merged;
          end
        end else begin
          state_d = ST_RD;
        end
      end
      ST_RD: state_d = ST_CAP;
      ST_CAP: begin
        if (!r_we_q) begin
          rdata_en = 1'b1;
          rvalid_d = 1'b1;
          state_d  = ST_IDLE;
        end else begin
          w_en     = 1'b1;
          w_addr_d = r_aligned;
          w_word_d = rmw_merged;
          state_d  = ST_WR;
        end
      end
      ST_WR: if (slow) begin
        tmr_start = 1'b1;
        state_d   = ST_STALL;
      end
      default: ;
    endcase
    if (wr_fin) begin
      if (pend_q) begin
        w_en     = 1'b1;
        w_addr_d = CMD_WORD;
        w_word_d = hold_q;
        pend_d   = 1'b0;
        state_d  = ST_WR;
      end else begin
        state_d = ST_IDLE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      state_q   <= ST_IDLE;
      pend_q    <= 1'b0;
      up_rvalid <= 1'b0;
      up_rdata  <= 32'd0;
      r_we_q    <= 1'b0;
      r_size_q  <= 2'd0;
      r_addr_q  <= '0;
      r_wdata_q <= 32'd0;
      w_addr_q  <= '0;
      w_word_q  <= 32'd0;
      hold_q    <= 32'd0;
    end else begin
      state_q   <= state_d;
      pend_q    <= pend_d;
      up_rvalid <= rvalid_d;
      if (rdata_en) up_rdata <= lane_extract(dn_rdata, r_addr_q[1:0], r_size_q);
      if (rq_en) begin
        r_we_q    <= up_we;
        r_size_q  <= up_size;
        r_addr_q  <= up_addr;
        r_wdata_q <= up_wdata;
      end
      if (w_en) begin
        w_addr_q <= w_addr_d;
        w_word_q <= w_word_d;
      end
      if (hold_en) hold_q <= sh_merged;
    end
  end

  assert_dn_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n_s)
    dn_req |-> (dn_addr[1:0] == 2'b00));
  assert_one_outstanding_R14: assert property (@(posedge clk) disable iff (!rst_n_s)
    dn_req |-> !up_ready);
  assert_rvalid_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n_s)
    up_rvalid |=> !up_rvalid);
  assert_flush_block_first_R8: assert property (@(posedge clk) disable iff (!rst_n_s)
    (dn_req && dn_we && pend_q) |-> (dn_addr == BLK_WORD));
  assert_fast_no_hold_R13: assert property (@(posedge clk) disable iff (!rst_n_s)
    (dn_we && (card_hz > SLOW_LIMIT_HZ)) |=> !tmr_busy);
endmodule

// File: tb/tb_subword_coalescer.sv
module tb_subword_coalescer;
  localparam int MHZ = 200;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] card_hz;
  logic        up_req, up_we;
  logic [1:0]  up_size;
  logic [7:0]  up_addr;
  logic [31:0] up_wdata;
  logic        up_ready, up_rvalid;
  logic [31:0] up_rdata;
  logic        dn_req, dn_we;
  logic [7:0]  dn_addr;
  logic [31:0] dn_wdata, dn_rdata;

  always #2.5 clk = ~clk;

  subword_coalescer #(.ADDR_W(8), .SYS_MHZ(MHZ)) dut (
    .clk(clk), .rst_n(rst_n), .card_hz(card_hz),
    .up_req(up_req), .up_we(up_we), .up_size(up_size), .up_addr(up_addr), .up_wdata(up_wdata),
    .up_ready(up_ready), .up_rvalid(up_rvalid), .up_rdata(up_rdata),
    .dn_req(dn_req), .dn_we(dn_we), .dn_addr(dn_addr), .dn_wdata(dn_wdata), .dn_rdata(dn_rdata)
  );

  logic [31:0] mem [0:63];
  int          wr_cnt;
  logic [7:0]  last_a, prev_a;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 64; i++) mem[i] <= 32'd0;
      wr_cnt <= 0;
      last_a <= 8'hFF;
      prev_a <= 8'hFF;
      dn_rdata <= 32'd0;
    end else if (dn_req) begin
      if (dn_we) begin
        mem[dn_addr[7:2]] <= dn_wdata;
        wr_cnt <= wr_cnt + 1;
        prev_a <= last_a;
        last_a <= dn_addr;
      end
      dn_rdata <= mem[dn_addr[7:2]];
    end
  end

  int  n_chk = 0;
  int  n_fail = 0;
  bit  finished = 0;

  task automatic check(input int rq, input logic [31:0] act, input logic [31:0] exp,
                       input string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic access(input logic we, input logic [1:0] sz, input logic [7:0] addr,
                        input logic [31:0] data, output logic [31:0] rd,
                        output int busy, output int nwr);
    int w0;
    @(negedge clk);
    up_req = 1'b1; up_we = we; up_size = sz; up_addr = addr; up_wdata = data;
    w0 = wr_cnt;
    while (!up_ready) @(negedge clk);
    @(negedge clk);
    up_req = 1'b0;
    busy = 0;
    rd = 32'hDEAD_DEAD;
    while (!up_ready) begin
      busy++;
      @(negedge clk);
    end
    if (up_rvalid) rd = up_rdata;
    nwr = wr_cnt - w0;
  endtask

  typedef struct packed {
    logic        we;
    logic [1:0]  sz;
    logic [7:0]  addr;
    logic [31:0] data;
    logic [7:0]  chk;
    logic [31:0] exp;
    logic [1:0]  nwr;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VECS [0:NV-1] = '{
    '{1'b1, 2'd2, 8'h20, 32'h11223344, 8'h20, 32'h11223344, 2'd1, 4'd10}, // R10 word write
    '{1'b0, 2'd1, 8'h22, 32'h0,        8'h00, 32'h00001122, 2'd0, 4'd2},  // R2 upper half
    '{1'b0, 2'd1, 8'h20, 32'h0,        8'h00, 32'h00003344, 2'd0, 4'd2},  // R2 lower half
    '{1'b0, 2'd0, 8'h21, 32'h0,        8'h00, 32'h00000033, 2'd0, 4'd3},  // R3 lane 1
    '{1'b0, 2'd0, 8'h23, 32'h0,        8'h00, 32'h00000011, 2'd0, 4'd3},  // R3 lane 3
    '{1'b1, 2'd0, 8'h22, 32'h000000AB, 8'h20, 32'h11AB3344, 2'd1, 4'd4},  // R4 byte rmw
    '{1'b1, 2'd1, 8'h22, 32'h0000BEEF, 8'h20, 32'hBEEF3344, 2'd1, 4'd5},  // R5 half rmw
    '{1'b1, 2'd1, 8'h24, 32'h00005566, 8'h24, 32'h00005566, 2'd1, 4'd5},  // R5 low half
    '{1'b0, 2'd2, 8'h20, 32'h0,        8'h00, 32'hBEEF3344, 2'd0, 4'd10}, // R10 word read
    '{1'b1, 2'd1, 8'h04, 32'h00000200, 8'h04, 32'h00000000, 2'd0, 4'd6},  // R6 block size held
    '{1'b1, 2'd1, 8'h06, 32'h00000001, 8'h04, 32'h00000000, 2'd0, 4'd6},  // R6 block count held
    '{1'b1, 2'd1, 8'h0C, 32'h00000011, 8'h0C, 32'h00AA0000, 2'd0, 4'd7},  // R7 transfer held
    '{1'b1, 2'd1, 8'h0E, 32'h00001234, 8'h0C, 32'h12340011, 2'd2, 4'd8},  // R8 flush
    '{1'b0, 2'd2, 8'h04, 32'h0,        8'h00, 32'h00010200, 2'd0, 4'd8},  // R8 block word
    '{1'b1, 2'd1, 8'h0E, 32'h00000510, 8'h0C, 32'h05100011, 2'd1, 4'd9},  // R9 single write
    '{1'b1, 2'd0, 8'h05, 32'h00000077, 8'h04, 32'h00017700, 2'd1, 4'd4},  // R4 byte in block word
    '{1'b0, 2'd1, 8'h0E, 32'h0,        8'h00, 32'h00000510, 2'd0, 4'd2},  // R2 read command half
    '{1'b0, 2'd0, 8'h0C, 32'h0,        8'h00, 32'h00000011, 2'd0, 4'd3}   // R3 read transfer byte
  };

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    int busy, nwr;
    rst_n = 1'b0; card_hz = 32'd25_000_000;
    up_req = 1'b0; up_we = 1'b0; up_size = 2'd0; up_addr = 8'h0; up_wdata = 32'h0;
    repeat (3) @(negedge clk);
    check(1, {31'd0, up_ready}, 32'd1, "ready in reset");   // R1
    check(1, {31'd0, up_rvalid}, 32'd0, "rvalid in reset"); // R1
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(1, {31'd0, up_ready}, 32'd1, "ready after reset"); // R1

    // R1: empty shadows, one write carrying a zero transfer half
    access(1'b1, 2'd1, 8'h0E, 32'h000000AA, rd, busy, nwr);
    check(1, nwr, 1, "first command write count");
    check(1, mem[3], 32'h00AA0000, "first command word");

    for (int i = 0; i < NV; i++) begin
      access(VECS[i].we, VECS[i].sz, VECS[i].addr, VECS[i].data, rd, busy, nwr);
      if (VECS[i].we) check(int'(VECS[i].rq), mem[VECS[i].chk[7:2]], VECS[i].exp, "stored word");
      else check(int'(VECS[i].rq), rd, VECS[i].exp, "read data");
      check(int'(VECS[i].rq), nwr, int'(VECS[i].nwr), "downstream write count");
      if (VECS[i].nwr == 2'd2) begin
        check(8, {24'd0, prev_a}, 32'h04, "flush first address");  // R8
        check(8, {24'd0, last_a}, 32'h0C, "flush second address"); // R8
      end
    end

    // R14: busy lengths with a fast card clock
    access(1'b0, 2'd1, 8'h20, 32'h0, rd, busy, nwr);
    check(14, busy, 2, "read busy cycles");
    access(1'b1, 2'd0, 8'h28, 32'h01, rd, busy, nwr);
    check(14, busy, 3, "rmw busy cycles");
    access(1'b1, 2'd2, 8'h28, 32'h5, rd, busy, nwr);
    check(14, busy, 1, "word write busy cycles");
    access(1'b1, 2'd1, 8'h06, 32'h0, rd, busy, nwr);
    check(14, busy, 0, "shadow write busy cycles");

    // R11: slow clock holds
    card_hz = 32'd400_000;
    access(1'b1, 2'd2, 8'h30, 32'h1, rd, busy, nwr);
    check(11, busy, 1 + 10 * MHZ, "hold at 400 kHz");
    card_hz = 32'd300_000;
    access(1'b1, 2'd2, 8'h30, 32'h2, rd, busy, nwr);
    check(11, busy, 1 + 14 * MHZ, "hold at 300 kHz rounded up");
    // R12: unknown clock
    card_hz = 32'd0;
    access(1'b1, 2'd2, 8'h30, 32'h3, rd, busy, nwr);
    check(12, busy, 1 + 10 * MHZ, "hold at zero clock");
    // R13: just above the limit
    card_hz = 32'd400_001;
    access(1'b1, 2'd2, 8'h30, 32'h4, rd, busy, nwr);
    check(13, busy, 1, "no hold above limit");
    check(13, mem[12], 32'h4, "word stored");

    // R8 + R11: flush under a slow clock, two holds
    card_hz = 32'd400_000;
    access(1'b1, 2'd1, 8'h04, 32'h0040, rd, busy, nwr);
    check(6, busy, 0, "block size held under slow clock"); // R6
    access(1'b1, 2'd1, 8'h0E, 32'h0001, rd, busy, nwr);
    check(8, nwr, 2, "slow flush write count");
    check(11, busy, 2 + 20 * MHZ, "slow flush busy cycles");
    check(8, {24'd0, prev_a}, 32'h04, "slow flush first address");
    check(8, mem[1], 32'h00000040, "slow flush block word");
    check(9, mem[3], 32'h00010011, "slow flush command word");

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule